// File: doc/BRIEF.md
# Instruction prefetch byte queue

This block holds instruction bytes that a bus-side fetcher has already read ahead of the decoder. The fetcher delivers 16-bit words. The decoder takes bytes one at a time because instructions vary from one to seven bytes in length. The fetcher can therefore keep the queue topped up while the decoder works, and the decoder finds its next byte waiting whenever the queue holds anything.

The block keeps its own 16-bit fetch offset and presents it to the fetcher, together with a request flag. The request flag is raised whenever there is room for a whole word. When the offset is odd, only the upper byte of the delivered word is stored, so that every later fetch is word-aligned. On a control transfer, a flush input discards every queued byte and loads a new fetch offset. The decoder then waits until bytes from the new target arrive.

Top module: `prefetch_q`

## Requirements
- R1: After reset the occupancy is 0, the output byte is not valid, a fetch is requested, and the fetch offset is 0.
- R2: Bytes leave in the order they were stored. For an aligned word, bits 7:0 leave before bits 15:8. The head byte holds its value while it is not popped.
- R3: `fetch_req_o` is high exactly when at least 2 of the DEPTH byte slots are free (occupancy <= DEPTH-2). Occupancy never exceeds DEPTH.
- R4: A word written while `fetch_req_o` is low is ignored. It changes neither the occupancy, the fetch offset, nor the bytes that are later read out.
- R5: A write at an odd fetch offset stores only bits 15:8 of the word, raises the occupancy by 1 and advances the offset by 1.
- R6: A write at an even fetch offset stores both bytes, raises the occupancy by 2 and advances the offset by 2.
- R7: A read request while the queue is empty has no effect, and `rd_valid_o` is low whenever the occupancy is 0.
- R8: A flush empties the queue and loads `flush_ofs_i` into the fetch offset on the next clock edge. A write or read presented in the same cycle as the flush is dropped.
- R9: The fetch offset wraps modulo 65536.
- R10: A read and an accepted write in the same cycle change the occupancy by the number of bytes written minus one.
- R11: A byte written on one clock edge is visible as the valid head byte right after that edge, if the queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Discard queued bytes and reload the fetch offset |
| flush_ofs_i | input | OFS_W | New fetch offset loaded on a flush |
| fetch_req_o | output | 1 | Room exists for one more word |
| fetch_ofs_o | output | OFS_W | Offset the fetcher should read next |
| wr_valid_i | input | 1 | Fetched word presented this cycle |
| wr_word_i | input | 16 | Fetched word; bits 7:0 sit at the lower address |
| rd_req_i | input | 1 | Decoder pops the head byte |
| rd_valid_o | output | 1 | Head byte is valid |
| rd_byte_o | output | 8 | Head byte |
| level_o | output | clog2(DEPTH+1) | Number of bytes held |

## Verification
The assertions take for granted that the fetcher presents a word only after seeing `fetch_req_o` high. They also assume that the read offset and the write offset never collide while the queue holds data. The block's own accept gating keeps that second condition true even when the fetcher misbehaves. The stimulus follows the fetcher rule in its sweeps, but deliberately breaks it in one directed case to show that an unrequested word is dropped. The sweeps combine pops of an empty queue, flushes carrying a write and a read, and flush targets at both parities and at the top of the offset range.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // How many bytes an incoming word contributes this cycle.
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_ONE  = 2'd1,
    WR_TWO  = 2'd2
  } wr_kind_e;

endpackage

// File: rtl/pfq_fetch_ptr.sv
module pfq_fetch_ptr #(
  parameter int OFS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic [OFS_W-1:0]     flush_ofs,
  input  pfq_pkg::wr_kind_e    wr_kind,
  output logic [OFS_W-1:0]     ofs_o,
  output logic                 odd_o
);
  import pfq_pkg::*;

  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q <= '0;
    end else if (flush) begin
      ofs_q <= flush_ofs;
    end else begin
      case (wr_kind)
        WR_ONE:  ofs_q <= ofs_q + OFS_W'(1);
        WR_TWO:  ofs_q <= ofs_q + OFS_W'(2);
        default: ofs_q <= ofs_q;
      endcase
    end
  end

  assign ofs_o = ofs_q;
  assign odd_o = ofs_q[0];

  // R8: a flush redirects the fetch offset
  a_r8_flush_load: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ofs_q == $past(flush_ofs)));

  // R6 / R9: aligned word advances by two, modulo the offset width
  a_r9_step_two: assert property (@(posedge clk) disable iff (rst)
    (!flush && wr_kind == WR_TWO) |=> (ofs_q == $past(ofs_q) + OFS_W'(2)));

  // R5: a single upper-lane byte leaves the offset even
  a_r5_odd_aligns: assert property (@(posedge clk) disable iff (rst)
    (!flush && wr_kind == WR_ONE) |=> (ofs_q[0] == 1'b0));

endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl #(
  parameter int DEPTH = 6,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_valid,
  input  logic               odd,
  input  logic               rd_req,
  output pfq_pkg::wr_kind_e  wr_kind_o,
  output logic [PW-1:0]      wr_ptr_o,
  output logic [PW-1:0]      wr_ptr_nx_o,
  output logic [PW-1:0]      rd_ptr_o,
  output logic [CW-1:0]      count_o,
  output logic               fetch_req_o,
  output logic               rd_valid_o
);
  import pfq_pkg::*;

  localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - 2);

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int unsigned k);
    int unsigned s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          accept, pop;
  logic [1:0]    n_wr;
  wr_kind_e      kind;

  assign fetch_req_o = (count_q <= ROOM_MAX);
  assign rd_valid_o  = (count_q != '0);
  assign accept      = !flush && wr_valid && fetch_req_o;
  assign pop         = !flush && rd_req && rd_valid_o;

  always_comb begin
    if (!accept)  kind = WR_NONE;
    else if (odd) kind = WR_ONE;
    else          kind = WR_TWO;
  end

  assign n_wr = (kind == WR_TWO) ? 2'd2 : ((kind == WR_ONE) ? 2'd1 : 2'd0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wrap_add(wr_ptr_q, int'(n_wr));
      rd_ptr_q <= wrap_add(rd_ptr_q, pop ? 1 : 0);
      count_q  <= count_q + CW'(n_wr) - CW'(pop);
    end
  end

  assign wr_kind_o   = kind;
  assign wr_ptr_o    = wr_ptr_q;
  assign wr_ptr_nx_o = wrap_add(wr_ptr_q, 1);
  assign rd_ptr_o    = rd_ptr_q;
  assign count_o     = count_q;

  // R3: occupancy bounded by the storage depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

  // R8: flush leaves an empty queue
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count_q == '0));

  // R4: no bytes enter while room for a word is missing
  a_r4_no_write_short: assert property (@(posedge clk) disable iff (rst)
    (count_q > ROOM_MAX) |-> (kind == WR_NONE));

  // R7: popping an empty queue leaves it empty
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0 && !wr_valid) |=> (count_q == '0));

endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int DEPTH = 6,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we0,
  input  logic [PW-1:0] wa0,
  input  logic [7:0]    d0,
  input  logic          we1,
  input  logic [PW-1:0] wa1,
  input  logic [7:0]    d1,
  input  logic [PW-1:0] ra,
  output logic [7:0]    q
);

  logic [7:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we0 && wa0 == PW'(i))      slot[i] <= d0;
      else if (we1 && wa1 == PW'(i)) slot[i] <= d1;
    end
  end

  assign q = slot[ra];

endmodule

// File: rtl/prefetch_q.sv
module prefetch_q #(
  parameter int DEPTH = 6,
  parameter int OFS_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush_i,
  input  logic [OFS_W-1:0]             flush_ofs_i,
  output logic                         fetch_req_o,
  output logic [OFS_W-1:0]             fetch_ofs_o,
  input  logic                         wr_valid_i,
  input  logic [15:0]                  wr_word_i,
  input  logic                         rd_req_i,
  output logic                         rd_valid_o,
  output logic [7:0]                   rd_byte_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o
);
  import pfq_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  wr_kind_e      kind;
  logic          odd;
  logic [PW-1:0] wr_ptr, wr_ptr_nx, rd_ptr;
  logic [7:0]    lane0;

  pfq_fetch_ptr #(.OFS_W(OFS_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_i),
    .flush_ofs (flush_ofs_i),
    .wr_kind   (kind),
    .ofs_o     (fetch_ofs_o),
    .odd_o     (odd)
  );

  pfq_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush_i),
    .wr_valid    (wr_valid_i),
    .odd         (odd),
    .rd_req      (rd_req_i),
    .wr_kind_o   (kind),
    .wr_ptr_o    (wr_ptr),
    .wr_ptr_nx_o (wr_ptr_nx),
    .rd_ptr_o    (rd_ptr),
    .count_o     (level_o),
    .fetch_req_o (fetch_req_o),
    .rd_valid_o  (rd_valid_o)
  );

  // Odd offset: the upper lane is the only byte at or after the target.
  assign lane0 = odd ? wr_word_i[15:8] : wr_word_i[7:0];

  pfq_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
    .clk (clk),
    .we0 (kind != WR_NONE),
    .wa0 (wr_ptr),
    .d0  (lane0),
    .we1 (kind == WR_TWO),
    .wa1 (wr_ptr_nx),
    .d1  (wr_word_i[15:8]),
    .ra  (rd_ptr),
    .q   (rd_byte_o)
  );

  // R2: an unpopped head byte stays put, even while words arrive
  a_r2_head_holds: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_req_i && !flush_i) |=> (rd_valid_o && $stable(rd_byte_o)));

  // R3: request flag never raised without room for a word
  a_r3_req_room: assert property (@(posedge clk) disable iff (rst)
    fetch_req_o |-> (level_o <= CW'(DEPTH - 2)));

endmodule

// File: tb/prefetch_q_tb.sv
`timescale 1ns/1ps
module prefetch_q_tb;
  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_i = 1'b0;
  logic [15:0] flush_ofs_i = '0;
  logic        fetch_req_o;
  logic [15:0] fetch_ofs_o;
  logic        wr_valid_i = 1'b0;
  logic [15:0] wr_word_i = '0;
  logic        rd_req_i = 1'b0;
  logic        rd_valid_o;
  logic [7:0]  rd_byte_o;
  logic [2:0]  level_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0]  mq[$];
  logic [15:0] mofs = '0;

  always #2 clk = ~clk;

  prefetch_q #(.DEPTH(DEPTH), .OFS_W(16)) u_dut (
    .clk(clk), .rst(rst), .flush_i(flush_i), .flush_ofs_i(flush_ofs_i),
    .fetch_req_o(fetch_req_o), .fetch_ofs_o(fetch_ofs_o),
    .wr_valid_i(wr_valid_i), .wr_word_i(wr_word_i), .rd_req_i(rd_req_i),
    .rd_valid_o(rd_valid_o), .rd_byte_o(rd_byte_o), .level_o(level_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp();
    chk(int'(level_o), mq.size(), "R10 level");
    chk(int'(rd_valid_o), int'(mq.size() > 0), "R7 rd_valid");
    if (mq.size() > 0) chk(int'(rd_byte_o), int'(mq[0]), "R2 head byte");
    chk(int'(fetch_req_o), int'(mq.size() <= DEPTH - 2), "R3 fetch_req");
    chk(int'(fetch_ofs_o), int'(mofs), "R9 fetch offset");
  endtask

  // Drive one cycle, advance the reference, then compare after the edge.
  task automatic cyc(input bit f, input logic [15:0] fo, input bit wv,
                     input logic [15:0] wd, input bit rr);
    bit acc;
    flush_i = f; flush_ofs_i = fo; wr_valid_i = wv; wr_word_i = wd; rd_req_i = rr;
    if (f) begin
      mq.delete();
      mofs = fo;
    end else begin
      acc = wv && (mq.size() <= DEPTH - 2);
      if (rr && mq.size() > 0) void'(mq.pop_front());
      if (acc) begin
        if (mofs[0]) begin
          mq.push_back(wd[15:8]); mofs = mofs + 16'd1;
        end else begin
          mq.push_back(wd[7:0]); mq.push_back(wd[15:8]); mofs = mofs + 16'd2;
        end
      end
    end
    @(posedge clk); #1;
    flush_i = 0; wr_valid_i = 0; rd_req_i = 0;
    cmp();
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk(int'(level_o), 0, "R1 level");
    chk(int'(rd_valid_o), 0, "R1 rd_valid");
    chk(int'(fetch_req_o), 1, "R1 fetch_req");
    chk(int'(fetch_ofs_o), 0, "R1 offset");

    // R6 / R11: aligned word, head visible at once
    cyc(0, 0, 1, 16'h2211, 0);
    chk(int'(level_o), 2, "R6 level");
    chk(int'(fetch_ofs_o), 2, "R6 offset");
    chk(int'(rd_byte_o), 'h11, "R11 head");
    cyc(0, 0, 1, 16'h4433, 0);
    cyc(0, 0, 1, 16'h6655, 0);
    chk(int'(fetch_req_o), 0, "R3 full no req");
    // R4: unrequested word dropped
    cyc(0, 0, 1, 16'h8877, 0);
    chk(int'(level_o), 6, "R4 level");
    chk(int'(fetch_ofs_o), 6, "R4 offset");
    for (int i = 0; i < 6; i++) begin
      chk(int'(rd_byte_o), 'h11 * (i + 1), "R2 order");
      cyc(0, 0, 0, 0, 1);
    end
    chk(int'(level_o), 0, "R4 nothing extra");
    // R7: pop on empty
    cyc(0, 0, 0, 0, 1);
    chk(int'(level_o), 0, "R7 level");
    chk(int'(rd_valid_o), 0, "R7 valid");

    // R8: flush drops same-cycle write and read
    cyc(0, 0, 1, 16'h0201, 0);
    cyc(1, 16'h0003, 1, 16'h9999, 1);
    chk(int'(level_o), 0, "R8 empty");
    chk(int'(fetch_ofs_o), 3, "R8 offset");
    // R5: odd target keeps only bits 15:8
    cyc(0, 0, 1, 16'hAABB, 0);
    chk(int'(level_o), 1, "R5 level");
    chk(int'(fetch_ofs_o), 4, "R5 offset");
    chk(int'(rd_byte_o), 'hAA, "R5 byte");
    // R10: read with write in one cycle
    cyc(0, 0, 1, 16'hDDCC, 1);
    chk(int'(level_o), 2, "R10 level");
    chk(int'(rd_byte_o), 'hCC, "R10 head");

    // R9: wrap at the top of the offset range
    cyc(1, 16'hFFFF, 0, 0, 0);
    cyc(0, 0, 1, 16'h1234, 0);
    chk(int'(fetch_ofs_o), 0, "R9 odd wrap");
    chk(int'(rd_byte_o), 'h12, "R9 byte");
    cyc(1, 16'hFFFE, 0, 0, 0);
    cyc(0, 0, 1, 16'h5678, 0);
    chk(int'(fetch_ofs_o), 0, "R9 even wrap");

    // Sweeps from several targets with mixed traffic
    lf = 16'hACE1;
    for (int s = 0; s < 6; s++) begin
      logic [15:0] tgt;
      tgt = (s == 0) ? 16'h0000 : (s == 1) ? 16'h0001 : (s == 2) ? 16'hFFFE :
            (s == 3) ? 16'hFFFF : (s == 4) ? 16'h7FFF : 16'h1234;
      cyc(1, tgt, 1, lf, 1);
      for (int k = 0; k < 800; k++) begin
        bit f, wv, rr;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        f  = (lf[7:3] == 5'd0);
        wv = lf[0] | lf[1];
        if (!f && mq.size() > DEPTH - 2) wv = 0;
        rr = lf[2] ^ lf[5];
        cyc(f, {lf[3:0], lf[15:4]}, wv, lf ^ 16'h5A5A, rr);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule